// File: doc/BRIEF.md
# Highway and Farm Road Intersection Signal Controller

This block sequences the lamps of a crossing between a main highway and a side farm road. The highway holds green by default. A vehicle sensor on the farm road asks for service. The controller then moves the highway through amber to red, gives the farm road a green, and returns control to the highway through a farm-road amber.

A single internal interval counter times every phase. It restarts whenever the phase changes. A short limit sets the length of each amber phase. A long limit sets both the minimum highway green and the maximum farm-road green. Both limits are parameters. Reset is synchronous and active high. All lamp outputs are registered-state decodes, so they change only on a clock edge.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the controller enters highway-green (`hw_green`=1, `fr_red`=1, all other lamps 0), and its interval counter restarts at zero.
- R2: In highway-green with `car_waiting` low, the next phase is highway-green again, however long the phase has already lasted.
- R3: Highway-green changes to highway-amber only when `car_waiting` is high and at least LONG_CYC cycles have passed in the phase. The earliest exit therefore comes after exactly LONG_CYC+1 cycles of highway green.
- R4: Highway-amber lasts exactly SHORT_CYC+1 cycles and is then followed by farm-green.
- R5: Farm-green changes to farm-amber in the cycle after `car_waiting` is sampled low, or after LONG_CYC+1 cycles in the phase, whichever comes first.
- R6: Farm-amber lasts exactly SHORT_CYC+1 cycles and is then followed by highway-green. The counter restarts, so the following highway green again lasts at least LONG_CYC+1 cycles.
- R7: Each road has exactly one lamp lit in every cycle. The two roads are never both showing green or amber.
- R8: The lamp patterns per phase are as follows. Highway-green shows `hw_green` and `fr_red`. Highway-amber shows `hw_amber` and `fr_red`. Farm-green shows `fr_green` and `hw_red`. Farm-amber shows `fr_amber` and `hw_red`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_waiting | input | 1 | Farm-road vehicle sensor, high when a car is present |
| hw_green | output | 1 | Highway green lamp |
| hw_amber | output | 1 | Highway amber lamp |
| hw_red | output | 1 | Highway red lamp |
| fr_green | output | 1 | Farm-road green lamp |
| fr_amber | output | 1 | Farm-road amber lamp |
| fr_red | output | 1 | Farm-road red lamp |

## Verification
The assertions check the following on every cycle:
- Per-road one-hot lamps and the absence of conflicting go signals.
- The reset landing state.
- The legal successor of each phase.
- The immediate farm-green exit when the sensor drops.
- The highway hold while no car is present.

Phase lengths can only be shown by the bench's scenarios, because they depend on the counter limits. These are the minimum highway green, the exact amber durations and the farm-green cap. The bench checks them with a cycle-accurate model under random and held sensor patterns.

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic car_waiting,
  output logic hw_green,
  output logic hw_amber,
  output logic hw_red,
  output logic fr_green,
  output logic fr_amber,
  output logic fr_red
);
  localparam int CW = $clog2(LONG_CYC + 1);

  typedef enum logic [1:0] {HWY_GO, HWY_WARN, FARM_GO, FARM_WARN} phase_t;

  phase_t          phase, phase_nx;
  logic [CW-1:0]   elapsed;
  logic            short_done, long_done, restart;

  assign short_done = elapsed >= CW'(SHORT_CYC);
  assign long_done  = elapsed >= CW'(LONG_CYC);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      HWY_GO:    if (long_done && car_waiting)  phase_nx = HWY_WARN;
      HWY_WARN:  if (short_done)                phase_nx = FARM_GO;
      FARM_GO:   if (long_done || !car_waiting) phase_nx = FARM_WARN;
      FARM_WARN: if (short_done)                phase_nx = HWY_GO;
      default:                                  phase_nx = HWY_GO;
    endcase
  end

  assign restart = phase_nx != phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= HWY_GO;
      elapsed <= '0;
    end else begin
      phase <= phase_nx;
      if (restart)         elapsed <= '0;
      else if (!long_done) elapsed <= elapsed + 1'b1;
    end
  end

  assign hw_green = phase == HWY_GO;
  assign hw_amber = phase == HWY_WARN;
  assign hw_red   = phase == FARM_GO || phase == FARM_WARN;
  assign fr_green = phase == FARM_GO;
  assign fr_amber = phase == FARM_WARN;
  assign fr_red   = phase == HWY_GO || phase == HWY_WARN;
endmodule

// File: rtl/xroad_signal_chk.sv
module xroad_signal_chk (
  input logic clk,
  input logic rst,
  input logic car_waiting,
  input logic hw_green,
  input logic hw_amber,
  input logic hw_red,
  input logic fr_green,
  input logic fr_amber,
  input logic fr_red
);
  p_reset_r1: assert property (@(posedge clk) rst |=> hw_green && fr_red);

  p_hold_no_car_r2: assert property (@(posedge clk) disable iff (rst)
    hw_green && !car_waiting |=> hw_green);

  p_hwy_exit_r3: assert property (@(posedge clk) disable iff (rst)
    hw_green |=> hw_green || hw_amber);

  p_hwy_amber_next_r4: assert property (@(posedge clk) disable iff (rst)
    hw_amber |=> hw_amber || fr_green);

  p_farm_leave_r5: assert property (@(posedge clk) disable iff (rst)
    fr_green && !car_waiting |=> fr_amber);

  p_farm_amber_next_r6: assert property (@(posedge clk) disable iff (rst)
    fr_amber |=> fr_amber || hw_green);

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({hw_green, hw_amber, hw_red}) == 1 &&
    $countones({fr_green, fr_amber, fr_red}) == 1);

  p_no_conflict_r7: assert property (@(posedge clk) disable iff (rst)
    !((hw_green || hw_amber) && (fr_green || fr_amber)));

  p_pairing_r8: assert property (@(posedge clk) disable iff (rst)
    (hw_green || hw_amber) == fr_red);
endmodule

bind xroad_signal_ctrl xroad_signal_chk u_chk (
  .clk(clk), .rst(rst), .car_waiting(car_waiting),
  .hw_green(hw_green), .hw_amber(hw_amber), .hw_red(hw_red),
  .fr_green(fr_green), .fr_amber(fr_amber), .fr_red(fr_red)
);

// File: tb/test_xroad_signal_ctrl.sv
module test_xroad_signal_ctrl;
  localparam int S = 3;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car = 1'b0;
  logic hg, ha, hr, fg, fa, fr;

  int checks = 0;
  int failures = 0;
  int m_ph = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  xroad_signal_ctrl #(.SHORT_CYC(S), .LONG_CYC(L)) i_xroad_signal_ctrl (
    .clk(clk), .rst(rst), .car_waiting(car),
    .hw_green(hg), .hw_amber(ha), .hw_red(hr),
    .fr_green(fg), .fr_amber(fa), .fr_red(fr)
  );

  function automatic logic [5:0] lamps_for(int ph);
    case (ph)
      0:       return 6'b100_001;
      1:       return 6'b010_001;
      2:       return 6'b001_100;
      default: return 6'b001_010;
    endcase
  endfunction

  function automatic string tag_for(int ph);
    case (ph)
      0:       return "R3";
      1:       return "R4";
      2:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s lamps actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(logic c);
    int nx = m_ph;
    bit sd = m_cnt >= S;
    bit ld = m_cnt >= L;
    case (m_ph)
      0: if (ld && c)  nx = 1;
      1: if (sd)       nx = 2;
      2: if (ld || !c) nx = 3;
      default: if (sd) nx = 0;
    endcase
    if (rst) begin
      m_ph = 0; m_cnt = 0;
    end else begin
      if (nx != m_ph) m_cnt = 0;
      else if (!ld) m_cnt++;
      m_ph = nx;
    end
  endtask

  task automatic cycle(logic c, string tag);
    logic [5:0] exp_l;
    car = c;
    @(posedge clk);
    model_step(c);
    @(negedge clk);
    exp_l = lamps_for(m_ph);
    check(tag.len() ? tag : tag_for(m_ph), {hg, ha, hr, fg, fa, fr}, exp_l);
    checks++;
    if (($countones({hg, ha, hr}) != 1) || ($countones({fg, fa, fr}) != 1) ||
        ((hg || ha) && (fg || fa))) begin
      failures++;
      $display("FAIL R7 lamps actual=%b expected one per road, no conflict", {hg, ha, hr, fg, fa, fr});
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20250));
    rst = 1'b1;
    @(negedge clk);
    cycle(1'b1, "R1");
    cycle(1'b0, "R1");
    rst = 1'b0;

    // R2: highway stays green with no farm car for a long time
    for (int i = 0; i < 4 * L; i++) cycle(1'b0, "R2");

    // R3: minimum highway green after a phase restart, car held high
    rst = 1'b1; cycle(1'b0, "R1"); rst = 1'b0;
    n = 0;
    while (hg && n < 100) begin cycle(1'b1, ""); n++; end
    checks++;
    if (n != L + 1) begin
      failures++;
      $display("FAIL R3 green cycles actual=%0d expected=%0d", n, L + 1);
    end
    // R4: highway amber duration (first amber cycle already observed)
    n = 1;
    while (ha && n < 100) begin cycle(1'b1, ""); if (ha) n++; end
    checks++;
    if (n != S + 1) begin
      failures++;
      $display("FAIL R4 amber cycles actual=%0d expected=%0d", n, S + 1);
    end
    // R5: car held, farm green capped by long interval
    n = 1;
    while (fg && n < 100) begin cycle(1'b1, ""); if (fg) n++; end
    checks++;
    if (n != L + 1) begin
      failures++;
      $display("FAIL R5 farm green cycles actual=%0d expected=%0d", n, L + 1);
    end
    // R6: farm amber then highway green
    for (int i = 0; i < S + 3; i++) cycle(1'b1, "");

    // random sensor traffic with long and short bursts
    for (int i = 0; i < 3000; i++) begin
      logic c = ($urandom % 100) < ((i / 200) % 2 ? 85 : 30);
      cycle(c, "");
    end

    // R1: reset mid farm green
    while (!fg) cycle(1'b1, "");
    rst = 1'b1; cycle(1'b1, "R1"); rst = 1'b0;
    for (int i = 0; i < L + 2; i++) cycle(1'b1, "");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule